// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block gathers a vector of level-sensitive, active-high interrupt request lines and merges them into a single interrupt line for a processor. Each request first passes through a two-flop synchronizer. A per-source enable bit then gates it. The OR of all gated bits is registered and drives the output. An enabled source keeps the output high for as long as its line is high. Nothing is latched, so the output falls once every enabled line has dropped.

Software uses a plain single-cycle register port with address, write data, write enable, read enable and read data. The enable bits cannot be written directly. A write to the enable-set address turns on every source whose data bit is 1. A write to the enable-clear address turns off every source whose data bit is 1. In both cases a 0 data bit leaves that source as it was. The gated word is read back at the status address. Interrupt handling software decides the service order by scanning that word.

Top module: `irq_agg`

## Requirements
- R1: While reset is high, and on the first cycle after it, all enable bits are 0, `irq_o` is 0 and `reg_rdata_o` is 0.
- R2: A read (`reg_rd_i`=1) of byte offset 0x00 returns, on `reg_rdata_o` in the following cycle, the status word. Bit i of that word is 1 exactly when synchronized source i is high and enable bit i is set.
- R3: A write to offset 0x08 sets enable bit i for every bit i of `reg_wdata_i` that is 1. All other enable bits keep their value.
- R4: A write to offset 0x0C clears enable bit i for every bit i of `reg_wdata_i` that is 1. All other enable bits keep their value. Writing 0xFFFFFFFF disables all 32 sources in one access.
- R5: Status is level-based and not latched. A source's status bit returns to 0 once its line has been low through the synchronizer, with no software action.
- R6: `irq_o` equals the OR of the status word of the previous cycle.
- R7: A change on `irq_src_i` becomes visible in status two clock edges after it is sampled, so a status read issued at the third edge after the change returns it.
- R8: Writes to offset 0x00, and writes to any offset other than 0x08 and 0x0C, leave the enables unchanged. Reads of any offset other than 0x00 return 0, and `reg_rdata_o` is 0 in every cycle that follows a cycle without a read.
- R9: An enable write changes status from the next cycle onward. In the cycle of the write, status and a same-cycle read of 0x00 use the previous enables.
- R10: Clearing the enable of a source whose line is still high removes its status bit. `irq_o` falls when no other enabled source is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | 32 | Level-sensitive active-high request lines, asynchronous |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_wr_i | input | 1 | Write enable, one access per cycle |
| reg_rd_i | input | 1 | Read enable |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Combined interrupt to the processor |

## Verification
Two functions can land in the same cycle: an enable write, and a source level arriving at the synchronizer output or being read back. The bench provokes this by raising or dropping lines so that they reach the second flop exactly when an enable-set or enable-clear write is issued. It also issues status reads in the cycle right after such writes and in the cycles around them, and runs a random phase that mixes both. A behavioural model that uses the old enables in the write cycle judges every cycle, comparing `irq_o` and `reg_rdata_o` on each clock.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NUM_SRC = 32;
    localparam int ADDR_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_EN_SET = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR = 8'h0C;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_EN_SET,
        SEL_EN_CLR
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
        src_vec_t data;
    } reg_req_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] addr);
        reg_sel_e sel;
        case (addr)
            OFS_STATUS: sel = SEL_STATUS;
            OFS_EN_SET: sel = SEL_EN_SET;
            OFS_EN_CLR: sel = SEL_EN_CLR;
            default:    sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_agg_mask.sv
module irq_agg_mask
    import irq_agg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_req_t req_i,
    output src_vec_t en_o
);
    src_vec_t en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (req_i.wr && req_i.sel == SEL_EN_SET) begin
            en_q <= en_q | req_i.data;
        end else if (req_i.wr && req_i.sel == SEL_EN_CLR) begin
            en_q <= en_q & ~req_i.data;
        end
    end

    assign en_o = en_q;
endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status
    import irq_agg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_req_t req_i,
    input  src_vec_t lines_i,
    input  src_vec_t en_i,
    output src_vec_t status_o,
    output src_vec_t rdata_o,
    output logic     irq_o
);
    src_vec_t gated;
    src_vec_t rdata_q;
    logic     irq_q;

    assign gated = lines_i & en_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q   <= |gated;
            rdata_q <= (req_i.rd && req_i.sel == SEL_STATUS) ? gated : '0;
        end
    end

    assign status_o = gated;
    assign rdata_o  = rdata_q;
    assign irq_o    = irq_q;
endmodule

// File: rtl/irq_agg.sv
module irq_agg
    import irq_agg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   irq_src_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [NUM_SRC-1:0]   reg_wdata_i,
    input  logic                 reg_wr_i,
    input  logic                 reg_rd_i,
    output logic [NUM_SRC-1:0]   reg_rdata_o,
    output logic                 irq_o
);
    reg_req_t req;
    src_vec_t src_sync;
    src_vec_t en_mask;
    src_vec_t status;

    always_comb begin
        req.wr   = reg_wr_i;
        req.rd   = reg_rd_i;
        req.sel  = decode_addr(reg_addr_i);
        req.data = reg_wdata_i;
    end

    irq_agg_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (irq_src_i),
        .sync_o  (src_sync)
    );

    irq_agg_mask u_mask (
        .clk   (clk),
        .rst   (rst),
        .req_i (req),
        .en_o  (en_mask)
    );

    irq_agg_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req),
        .lines_i  (src_sync),
        .en_i     (en_mask),
        .status_o (status),
        .rdata_o  (reg_rdata_o),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
    import irq_agg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [NUM_SRC-1:0] wdata,
    input logic              wr,
    input logic              rd,
    input logic [NUM_SRC-1:0] en,
    input logic [NUM_SRC-1:0] lines,
    input logic [NUM_SRC-1:0] rdata,
    input logic              irq
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (en == '0 && !irq && rdata == '0));

    assert_status_read_R2: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == OFS_STATUS) |=> rdata == $past(lines & en));

    assert_en_set_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFS_EN_SET) |=> ((en & $past(wdata)) == $past(wdata)));

    assert_en_clr_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFS_EN_CLR) |=> ((en & $past(wdata)) == '0));

    assert_irq_or_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq == $past(|(lines & en)));

    assert_en_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(wr && (addr == OFS_EN_SET || addr == OFS_EN_CLR)) |=> $stable(en));

    assert_rdata_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !(rd && addr == OFS_STATUS) |=> rdata == '0);
endmodule

bind irq_agg irq_agg_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .addr  (reg_addr_i),
    .wdata (reg_wdata_i),
    .wr    (reg_wr_i),
    .rd    (reg_rd_i),
    .en    (en_mask),
    .lines (src_sync),
    .rdata (reg_rdata_o),
    .irq   (irq_o)
);

// File: tb/irq_agg_bench.sv
module irq_agg_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src = '0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";
    bit    started = 0;
    bit    done = 0;

    // behavioural model state
    logic [31:0] sync_q[$];
    logic [31:0] mask_m = '0;
    logic        irq_m = 1'b0;
    logic [31:0] rdata_m = '0;

    irq_agg u_irq_agg (
        .clk(clk), .rst(rst), .irq_src_i(src), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        logic [31:0] st;
        started <= 1;
        if (rst) begin
            sync_q = '{32'h0, 32'h0};
            mask_m = '0;
            irq_m = 1'b0;
            rdata_m = '0;
        end else begin
            st = sync_q[0] & mask_m;
            irq_m = |st;
            rdata_m = (rd && addr == 8'h00) ? st : '0;
            if (wr && addr == 8'h08) mask_m = mask_m | wdata;
            else if (wr && addr == 8'h0C) mask_m = mask_m & ~wdata;
            sync_q.push_back(src);
            void'(sync_q.pop_front());
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            chk(cur_req, "irq_o", {31'b0, irq}, {31'b0, irq_m});
            chk(cur_req, "reg_rdata_o", rdata, rdata_m);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr = 0; rd = 0;
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1; rd = 0;
        @(negedge clk);
        wr = 0;
    endtask

    // issues a read; returns the data seen in the following cycle
    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1; wr = 0;
        @(negedge clk);
        rd = 0;
        d = rdata;
    endtask

    initial begin
        #800000;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        // R1 reset
        repeat (3) @(negedge clk);
        chk("R1", "irq in reset", {31'b0, irq}, 32'h0);
        rst = 0;
        idle(2);
        rd_reg(8'h00, d);
        chk("R1", "status after reset", d, 32'h0);

        // R3 set enables
        cur_req = "R3";
        src = 32'hA5A5_0F0F;
        idle(3);
        wr_reg(8'h08, 32'h0000_FFFF);
        rd_reg(8'h00, d);
        chk("R3", "status after set", d, 32'h0000_0F0F);
        chk("R6", "irq with enabled active", {31'b0, irq}, 32'h1);
        wr_reg(8'h08, 32'h8000_0000);
        rd_reg(8'h00, d);
        chk("R3", "status after second set", d, 32'h8000_0F0F);

        // R4 clear some enables
        cur_req = "R4";
        wr_reg(8'h0C, 32'h0000_0F00);
        rd_reg(8'h00, d);
        chk("R4", "status after clear", d, 32'h8000_000F);

        // R5 level, not latched
        cur_req = "R5";
        src = 32'h8000_0000;
        idle(3);
        rd_reg(8'h00, d);
        chk("R5", "status follows line", d, 32'h8000_0000);

        // R10 disable still-active source
        cur_req = "R10";
        wr_reg(8'h0C, 32'h8000_0000);
        idle(1);
        chk("R10", "irq after disabling active", {31'b0, irq}, 32'h0);
        rd_reg(8'h00, d);
        chk("R10", "status after disabling active", d, 32'h0);

        // R8 ignored writes and zero reads
        cur_req = "R8";
        wr_reg(8'h00, 32'hFFFF_FFFF);
        wr_reg(8'h04, 32'hFFFF_FFFF);
        wr_reg(8'h09, 32'hFFFF_FFFF);
        rd_reg(8'h00, d);
        chk("R8", "enables untouched by stray writes", d, 32'h0);
        wr_reg(8'h08, 32'hFFFF_FFFF);
        rd_reg(8'h08, d);
        chk("R8", "read of set offset", d, 32'h0);
        rd_reg(8'h0C, d);
        chk("R8", "read of clear offset", d, 32'h0);
        rd_reg(8'h10, d);
        chk("R8", "read of unmapped offset", d, 32'h0);
        rd_reg(8'h00, d);
        chk("R8", "status still live", d, 32'h8000_0000);

        // R7 synchronizer latency
        cur_req = "R7";
        @(negedge clk);
        src = 32'h0000_0101;
        addr = 8'h00; rd = 1;
        repeat (5) @(negedge clk);
        rd = 0;
        rd_reg(8'h00, d);
        chk("R7", "status after sync", d, 32'h0000_0101);

        // R4 all-ones clear in one access
        cur_req = "R4";
        wr_reg(8'h0C, 32'hFFFF_FFFF);
        rd_reg(8'h00, d);
        chk("R4", "all disabled", d, 32'h0);

        // R9 enable write collides with line arrival and reads
        cur_req = "R9";
        @(negedge clk);
        src = 32'h0000_00F0;
        @(negedge clk);
        addr = 8'h08; wdata = 32'h0000_0030; wr = 1;
        @(negedge clk);
        addr = 8'h00; wr = 0; rd = 1;
        @(negedge clk);
        addr = 8'h0C; wdata = 32'h0000_0010; wr = 1; rd = 0;
        @(negedge clk);
        addr = 8'h00; wr = 0; rd = 1;
        @(negedge clk);
        rd = 0;
        chk("R9", "status after collision", rdata, 32'h0000_0020);
        idle(2);

        // R2 random mix, judged by the model
        cur_req = "R2";
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if ((i % 7) == 0) src = $urandom;
            case ($urandom_range(0, 4))
                0: addr = 8'h00;
                1: addr = 8'h08;
                2: addr = 8'h0C;
                3: addr = 8'h04;
                default: addr = 8'h10;
            endcase
            wdata = $urandom;
            wr = $urandom_range(0, 1);
            rd = $urandom_range(0, 1);
        end
        idle(4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule